// File: doc/BRIEF.md
# Power Calibration Stage

This block sits between the raw power computation and the power registers and energy accumulators of a metering datapath. On every sample strobe it takes three raw power results: active power, fundamental reactive power, and an apparent power that it forms itself from a voltage rms and a current rms value. It scales each of them by one shared fractional gain of the form 1 + g/2^27, adds a separate offset for each quantity, and delivers three calibrated signed power values together with a one-cycle valid strobe.

When the voltage channel cannot be trusted, a configuration input can replace the measured voltage rms with a programmed nominal voltage in the apparent power product. All arithmetic is fixed-point. The gain product is computed at full width and truncated by an arithmetic shift. Each final sum saturates to the signed 32-bit range. The outputs change only on a sample strobe, two clocks after that strobe.

Top module: `pwr_cal_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_vld`, `cal_watt`, `cal_var` and `cal_va` are cleared to 0.
- R2: A one-cycle pulse on `in_vld` produces a one-cycle pulse on `out_vld` exactly two clock edges later. The outputs carry the result for the inputs that were present in the `in_vld` cycle. All inputs, including the gain and the offsets, are sampled in that cycle.
- R3: `cal_watt` = sat(raw + floor(raw*g/2^27) + ofs), where raw = `raw_watt`, g = `gain` and ofs = `ofs_watt`, all signed 32-bit two's complement values.
- R4: `cal_var` uses the same `gain` as `cal_watt` and its own offset `ofs_var` in the formula of R3. Each lane's offset affects only its own output.
- R5: The raw apparent power is min((V*I) >> 23, 2^31-1), with V and I taken as unsigned 32-bit values. `cal_va` applies the formula of R3 to this value, using `ofs_va`.
- R6: V in R5 is `vnom` when `nom_en` is 1 and `vrms` when `nom_en` is 0.
- R7: sat() clamps to the range [-2^31, 2^31-1]. A sum above the range yields 0x7FFFFFFF and a sum below it yields 0x80000000. This holds for gain-driven overflow and for offset-driven overflow alike.
- R8: While `in_vld` is low, changes on the data inputs leave all three outputs unchanged, and `out_vld` stays low two edges later.
- R9: With gain 0 and offset 0, a full-scale raw value of 10,356,306 passes through unchanged. V = 10,356,306 and I = 2^23 likewise give `cal_va` = 10,356,306.
- R10: The gain term is truncated toward minus infinity. For example, raw = -1 with g = 1 gives -2, and raw = 3 with g = -1 gives 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Sample strobe for the raw inputs |
| raw_watt | input | 32 | Raw active power, signed |
| raw_var | input | 32 | Raw fundamental reactive power, signed |
| vrms | input | 32 | Measured voltage rms, unsigned |
| irms | input | 32 | Current rms, unsigned |
| vnom | input | 32 | Programmed nominal voltage, unsigned |
| nom_en | input | 1 | 1 selects vnom in place of vrms |
| gain | input | 32 | Shared gain word g, signed |
| ofs_watt | input | 32 | Active power offset, signed |
| ofs_var | input | 32 | Reactive power offset, signed |
| ofs_va | input | 32 | Apparent power offset, signed |
| out_vld | output | 1 | One-cycle strobe marking new outputs |
| cal_watt | output | 32 | Calibrated active power, signed |
| cal_var | output | 32 | Calibrated reactive power, signed |
| cal_va | output | 32 | Calibrated apparent power, signed |

## Verification
The bench targets negative raw values with small positive gains, where a shift that rounds toward zero instead of down would return -1 rather than -2. It also targets sums just past either signed limit, where a design with no clamp would wrap to the opposite sign. It checks that the nominal voltage selection changes only the apparent result and that each offset lands on its own lane, so swapped lanes or a wrong selector show up as mismatched outputs. It changes inputs with no strobe present to catch a design that updates its outputs continuously, and it checks the two-clock latency so that an extra or a missing pipeline stage is caught.

// File: rtl/pwr_cal_pkg.sv
// Shared constants of the power calibration stage.
// Assumes every power, gain and offset word is signed two's complement.
package pwr_cal_pkg;
    localparam int unsigned PWR_W     = 32; // width of power, gain and offset words
    localparam int unsigned GAIN_FRAC = 27; // fractional bits of the gain word
    localparam int unsigned VA_SHIFT  = 23; // right shift applied to the V*I product
    localparam int unsigned N_LANES   = 3;  // active, reactive, apparent
    localparam int unsigned LANE_W    = 0;  // lane index: active power
    localparam int unsigned LANE_VAR  = 1;  // lane index: reactive power
    localparam int unsigned LANE_VA   = 2;  // lane index: apparent power
endpackage

// File: rtl/pwr_cal_capture.sv
// First pipeline stage. On a sample strobe it forms the raw apparent
// power from the selected voltage and the current rms, and registers the
// three raw powers, the gain and the offsets.
// Assumes the rms inputs are unsigned and that N lanes are ordered
// active, reactive, apparent.
module pwr_cal_capture #(
    parameter int unsigned W     = pwr_cal_pkg::PWR_W,
    parameter int unsigned SHIFT = pwr_cal_pkg::VA_SHIFT,
    parameter int unsigned N     = pwr_cal_pkg::N_LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic [W-1:0]        raw_watt,
    input  logic [W-1:0]        raw_var,
    input  logic [W-1:0]        vrms,
    input  logic [W-1:0]        irms,
    input  logic [W-1:0]        vnom,
    input  logic                nom_en,
    input  logic [W-1:0]        gain,
    input  logic [N-1:0][W-1:0] ofs,
    output logic                s1_vld,
    output logic [N-1:0][W-1:0] s1_raw,
    output logic [N-1:0][W-1:0] s1_ofs,
    output logic [W-1:0]        s1_gain
);
    localparam int unsigned PW = 2 * W;
    localparam logic [PW-1:0] VA_MAX = {{(W + 1){1'b0}}, {(W - 1){1'b1}}};

    logic [W-1:0]  v_sel;
    logic [PW-1:0] vi_prod;
    logic [PW-1:0] vi_scaled;
    logic [W-1:0]  va_raw;

    // Pick the voltage source, form V*I, shift it down and clamp it to the signed maximum.
    always_comb begin
        v_sel     = nom_en ? vnom : vrms;
        vi_prod   = {{W{1'b0}}, v_sel} * {{W{1'b0}}, irms};
        vi_scaled = vi_prod >> SHIFT;
        va_raw    = (vi_scaled > VA_MAX) ? VA_MAX[W-1:0] : vi_scaled[W-1:0];
    end

    // Capture every operand on the sample strobe; the valid flag follows the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_raw  <= '0;
            s1_ofs  <= '0;
            s1_gain <= '0;
        end else begin
            s1_vld <= in_vld;
            if (in_vld) begin
                s1_raw[pwr_cal_pkg::LANE_W]   <= raw_watt;
                s1_raw[pwr_cal_pkg::LANE_VAR] <= raw_var;
                s1_raw[pwr_cal_pkg::LANE_VA]  <= va_raw;
                s1_ofs  <= ofs;
                s1_gain <= gain;
            end
        end
    end

    // R2: the first stage flag follows the strobe one edge later
    p_stage_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> s1_vld);

    // R5: a zero current gives a zero raw apparent power
    p_va_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && irms == '0) |=> (s1_raw[pwr_cal_pkg::LANE_VA] == '0));

    // R6: with the nominal voltage selected, a zero nominal voltage forces zero
    p_nom_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && nom_en && vnom == '0) |=> (s1_raw[pwr_cal_pkg::LANE_VA] == '0));

    // R8: with no strobe, the captured operands stay put
    p_hold_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(s1_raw));
endmodule

// File: rtl/pwr_cal_lane.sv
// One calibration lane. It computes raw * (2^FRAC + g) at full width,
// shifts right arithmetically by FRAC (truncation toward minus infinity),
// adds the offset and saturates to the signed W-bit range. The result is
// registered when vld_i is high.
// Assumes raw, gain and offset are signed W-bit values.
module pwr_cal_lane #(
    parameter int unsigned W    = pwr_cal_pkg::PWR_W,
    parameter int unsigned FRAC = pwr_cal_pkg::GAIN_FRAC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic signed [W-1:0] raw_i,
    input  logic signed [W-1:0] gain_i,
    input  logic signed [W-1:0] ofs_i,
    output logic signed [W-1:0] q_o
);
    localparam int unsigned PW = 2 * W + 2;
    localparam logic signed [W+1:0]  UNITY = {{(W + 1 - FRAC){1'b0}}, 1'b1, {FRAC{1'b0}}};
    localparam logic signed [PW-1:0] MAXV  = {{(PW - W + 1){1'b0}}, {(W - 1){1'b1}}};
    localparam logic signed [PW-1:0] MINV  = {{(PW - W + 1){1'b1}}, {(W - 1){1'b0}}};

    logic signed [W+1:0]  mul;
    logic signed [PW-1:0] raw_x;
    logic signed [PW-1:0] mul_x;
    logic signed [PW-1:0] ofs_x;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic signed [PW-1:0] sum;
    logic signed [W-1:0]  sat_v;

    // Full-width gain multiply, truncating shift, offset add and clamp.
    always_comb begin
        mul    = {{2{gain_i[W-1]}}, gain_i} + UNITY;
        raw_x  = {{(W + 2){raw_i[W-1]}}, raw_i};
        mul_x  = {{W{mul[W+1]}}, mul};
        ofs_x  = {{(W + 2){ofs_i[W-1]}}, ofs_i};
        prod   = raw_x * mul_x;
        scaled = prod >>> FRAC;
        sum    = scaled + ofs_x;
        if (sum > MAXV)      sat_v = MAXV[W-1:0];
        else if (sum < MINV) sat_v = MINV[W-1:0];
        else                 sat_v = sum[W-1:0];
    end

    // Register the calibrated value on each valid operand set.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= '0;
        else if (vld_i) q_o <= sat_v;
    end

    // R8: output holds while no operand set arrives
    p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(q_o));

    // R7: an oversized sum lands on the positive limit
    p_sat_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && sum > MAXV) |=> (q_o == MAXV[W-1:0]));

    // R7: an undersized sum lands on the negative limit
    p_sat_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && sum < MINV) |=> (q_o == MINV[W-1:0]));

    // R3: zero gain and zero offset pass the raw value through
    p_unity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && gain_i == '0 && ofs_i == '0) |=> (q_o == $past(raw_i)));
endmodule

// File: rtl/pwr_cal_stage.sv
// Top of the power calibration stage: a capture stage followed by one
// calibration lane per power quantity, all lanes sharing one gain word.
// Latency is two clocks from in_vld to out_vld.
// Assumes a synchronous active-low reset held for at least one edge.
module pwr_cal_stage #(
    parameter int unsigned W     = pwr_cal_pkg::PWR_W,
    parameter int unsigned FRAC  = pwr_cal_pkg::GAIN_FRAC,
    parameter int unsigned SHIFT = pwr_cal_pkg::VA_SHIFT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] raw_watt,
    input  logic [W-1:0] raw_var,
    input  logic [W-1:0] vrms,
    input  logic [W-1:0] irms,
    input  logic [W-1:0] vnom,
    input  logic         nom_en,
    input  logic [W-1:0] gain,
    input  logic [W-1:0] ofs_watt,
    input  logic [W-1:0] ofs_var,
    input  logic [W-1:0] ofs_va,
    output logic         out_vld,
    output logic [W-1:0] cal_watt,
    output logic [W-1:0] cal_var,
    output logic [W-1:0] cal_va
);
    localparam int unsigned N = pwr_cal_pkg::N_LANES;

    logic [N-1:0][W-1:0] ofs_bus;
    logic                s1_vld;
    logic [N-1:0][W-1:0] s1_raw;
    logic [N-1:0][W-1:0] s1_ofs;
    logic [W-1:0]        s1_gain;
    logic [N-1:0][W-1:0] cal_bus;

    // Gather the per-lane offsets in lane order.
    always_comb begin
        ofs_bus[pwr_cal_pkg::LANE_W]   = ofs_watt;
        ofs_bus[pwr_cal_pkg::LANE_VAR] = ofs_var;
        ofs_bus[pwr_cal_pkg::LANE_VA]  = ofs_va;
    end

    pwr_cal_capture #(.W(W), .SHIFT(SHIFT), .N(N)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .raw_watt (raw_watt),
        .raw_var  (raw_var),
        .vrms     (vrms),
        .irms     (irms),
        .vnom     (vnom),
        .nom_en   (nom_en),
        .gain     (gain),
        .ofs      (ofs_bus),
        .s1_vld   (s1_vld),
        .s1_raw   (s1_raw),
        .s1_ofs   (s1_ofs),
        .s1_gain  (s1_gain)
    );

    for (genvar k = 0; k < N; k++) begin : g_lane
        pwr_cal_lane #(.W(W), .FRAC(FRAC)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_i  (s1_vld),
            .raw_i  (s1_raw[k]),
            .gain_i (s1_gain),
            .ofs_i  (s1_ofs[k]),
            .q_o    (cal_bus[k])
        );
    end

    // Second-stage valid flag, aligned with the lane registers.
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= s1_vld;
    end

    assign cal_watt = cal_bus[pwr_cal_pkg::LANE_W];
    assign cal_var  = cal_bus[pwr_cal_pkg::LANE_VAR];
    assign cal_va   = cal_bus[pwr_cal_pkg::LANE_VA];

    // R2: a strobe at the input reappears at the output two edges later
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> ##1 out_vld);
endmodule

// File: tb/pwr_cal_stage_test.sv
// Self-checking bench for pwr_cal_stage: directed corners plus seeded random.
module pwr_cal_stage_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] raw_watt = '0, raw_var = '0, vrms = '0, irms = '0, vnom = '0;
    logic        nom_en = 1'b0;
    logic [31:0] gain = '0, ofs_watt = '0, ofs_var = '0, ofs_va = '0;
    logic        out_vld;
    logic [31:0] cal_watt, cal_var, cal_va;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwr_cal_stage uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .raw_watt(raw_watt), .raw_var(raw_var), .vrms(vrms), .irms(irms),
        .vnom(vnom), .nom_en(nom_en), .gain(gain),
        .ofs_watt(ofs_watt), .ofs_var(ofs_var), .ofs_va(ofs_va),
        .out_vld(out_vld), .cal_watt(cal_watt), .cal_var(cal_var), .cal_va(cal_va)
    );

    // Expected calibrated value: raw + floor(raw*g/2^27) + ofs, clamped.
    function automatic logic [31:0] exp_cal(logic [31:0] r, logic [31:0] g, logic [31:0] o);
        longint rr = longint'($signed(r));
        longint gg = longint'($signed(g));
        longint oo = longint'($signed(o));
        longint t  = rr + ((rr * gg) >>> 27) + oo;
        if (t > 64'sd2147483647)  t = 64'sd2147483647;
        if (t < -64'sd2147483648) t = -64'sd2147483648;
        return t[31:0];
    endfunction

    // Expected raw apparent power: (V*I) >> 23, clamped to the signed maximum.
    function automatic logic [31:0] exp_va(logic [31:0] v, logic [31:0] i);
        longint unsigned p = (longint'(v) * longint'(i)) >> 23;
        if (p > 64'd2147483647) p = 64'd2147483647;
        return p[31:0];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One sample: drive at a falling edge, pulse in_vld, check two edges later.
    task automatic sample(string req,
                          logic [31:0] rw, logic [31:0] rv, logic [31:0] v, logic [31:0] i,
                          logic [31:0] vn, logic en, logic [31:0] g,
                          logic [31:0] ow, logic [31:0] ov, logic [31:0] oa);
        logic [31:0] ew, ev, ea;
        ew = exp_cal(rw, g, ow);
        ev = exp_cal(rv, g, ov);
        ea = exp_cal(exp_va(en ? vn : v, i), g, oa);
        @(negedge clk);
        raw_watt = rw; raw_var = rv; vrms = v; irms = i; vnom = vn; nom_en = en;
        gain = g; ofs_watt = ow; ofs_var = ov; ofs_va = oa; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        // Scramble operands after capture to prove they were sampled (R2).
        raw_watt = ~rw; gain = ~g; ofs_va = ~oa; irms = ~i;
        @(negedge clk);
        chk({req, " R2 vld"}, {31'd0, out_vld}, 32'd1);
        chk({req, " R3 watt"}, cal_watt, ew);
        chk({req, " R4 var"}, cal_var, ev);
        chk({req, " R5 va"}, cal_va, ea);
        @(negedge clk);
        chk({req, " R2 pulse"}, {31'd0, out_vld}, 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] hw, hv, ha;
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 vld", {31'd0, out_vld}, 32'd0);
        chk("R1 watt", cal_watt, 32'd0);
        chk("R1 var", cal_var, 32'd0);
        chk("R1 va", cal_va, 32'd0);
        rst_n = 1'b1;

        // R9: full-scale checkpoint
        sample("R9 fullscale", 32'd10356306, 32'd10356306, 32'd10356306, 32'h0080_0000,
               32'd0, 1'b0, 32'd0, 32'd0, 32'd0, 32'd0);
        chk("R9 watt value", cal_watt, 32'd10356306);
        chk("R9 va value", cal_va, 32'd10356306);

        // R10: truncation toward minus infinity
        sample("R10 neg", 32'hFFFF_FFFF, 32'd3, 32'd0, 32'd0, 32'd0, 1'b0,
               32'd1, 32'd0, 32'd0, 32'd0);
        chk("R10 watt -2", cal_watt, 32'hFFFF_FFFE);
        sample("R10 negg", 32'd3, 32'd3, 32'd0, 32'd0, 32'd0, 1'b0,
               32'hFFFF_FFFF, 32'd0, 32'd0, 32'd0);
        chk("R10 watt 2", cal_watt, 32'd2);

        // R7: saturation from gain, from offset, in both directions
        sample("R7 gain hi", 32'h7FFF_FFFF, 32'h8000_0000, 32'd0, 32'd0, 32'd0, 1'b0,
               32'h0800_0000, 32'd0, 32'd0, 32'd0);
        chk("R7 hi", cal_watt, 32'h7FFF_FFFF);
        chk("R7 lo", cal_var, 32'h8000_0000);
        sample("R7 ofs", 32'h7FFF_FFF0, 32'h8000_0010, 32'd0, 32'd0, 32'd0, 1'b0,
               32'd0, 32'd100, 32'hFFFF_FF00, 32'h8000_0000);
        chk("R7 ofs hi", cal_watt, 32'h7FFF_FFFF);
        chk("R7 ofs lo", cal_var, 32'h8000_0000);

        // R5: apparent product clamp
        sample("R5 clamp", 32'd0, 32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 1'b0,
               32'd0, 32'd0, 32'd0, 32'd0);
        chk("R5 va max", cal_va, 32'h7FFF_FFFF);

        // R6: nominal voltage replaces vrms
        sample("R6 nom on", 32'd5, 32'd6, 32'd1000, 32'h0100_0000, 32'd7000, 1'b1,
               32'd0, 32'd0, 32'd0, 32'd0);
        chk("R6 va nom", cal_va, 32'd14000);
        sample("R6 nom off", 32'd5, 32'd6, 32'd1000, 32'h0100_0000, 32'd7000, 1'b0,
               32'd0, 32'd0, 32'd0, 32'd0);
        chk("R6 va meas", cal_va, 32'd2000);

        // R4: separate offsets per lane
        sample("R4 ofs", 32'd100, 32'd100, 32'd100, 32'h0080_0000, 32'd0, 1'b0,
               32'd0, 32'd1, 32'd2, 32'd3);
        chk("R4 watt", cal_watt, 32'd101);
        chk("R4 var", cal_var, 32'd102);
        chk("R4 va", cal_va, 32'd103);

        // R8: inputs change without a strobe
        hw = cal_watt; hv = cal_var; ha = cal_va;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            raw_watt = $urandom; raw_var = $urandom; vrms = $urandom; irms = $urandom;
            gain = $urandom; ofs_watt = $urandom; ofs_var = $urandom; ofs_va = $urandom;
            nom_en = ~nom_en;
        end
        repeat (2) @(negedge clk);
        chk("R8 vld", {31'd0, out_vld}, 32'd0);
        chk("R8 watt", cal_watt, hw);
        chk("R8 var", cal_var, hv);
        chk("R8 va", cal_va, ha);

        // R3 R4 R5 R6: seeded random operands, small and full-range gains
        for (int k = 0; k < 300; k++) begin
            logic [31:0] g;
            g = (k % 2 == 0) ? {{12{1'b0}}, 20'($urandom)} - 32'h0008_0000 : 32'($urandom);
            sample("R3 rand", $urandom, $urandom, $urandom, $urandom, $urandom,
                   1'($urandom), g, $urandom, $urandom, $urandom);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule